// File: doc/BRIEF.md
# Channel-Gain List Scan Sequencer

This block drives an analog input path from a small on-chip list of sample entries. Each entry pairs a multiplexer channel address with an amplifier gain code. The list may name channels in any order, and it may name a channel more than once, so a channel listed twice is sampled twice as often as one listed once. The host fills the list through a write port and then issues one start command. From then on the hardware walks the list by itself. Before each conversion it places the entry's channel and gain on the front-end outputs, waits a programmable settle time and then strobes the converter. When the converter reports completion, it tags the result with the list position and the channel.

A sample trigger comes from one of three sources: a software strobe, an internal pacer counter or the rising edge of an external input. In continuous mode each trigger converts exactly one entry. In burst mode each trigger converts a programmable block of successive entries. A second counter sets the spacing between those conversions, so the block runs at the fastest rate the converter allows. A trigger that arrives while the sequencer is busy is flagged as an overrun and dropped. A stop command ends the run once any conversion already in progress has finished, and it returns the list position to the first entry.

Top module: `scan_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `conv_start`, `res_valid` and `overrun` are 0, and `mux_addr` and `gain_code` are 0.
- R2: When an entry is taken, its channel and gain appear on `mux_addr` and `gain_code` at the clock edge that sampled the trigger (continuous mode) or that ended the spacing interval (burst mode). Both outputs hold steady until the converter reports completion.
- R3: `conv_start` is a one-cycle pulse. It rises `cfg_settle`+1 clock edges after the entry's channel and gain are applied.
- R4: In continuous mode each trigger that arrives while the sequencer is waiting produces one conversion, on the next list entry. Entries are used in index order from 0 up to `cfg_last` and then wrap back to 0. Repeated channels are sampled once for each time they appear.
- R5: `cfg_src` selects the trigger. 0 is the `sw_trig` level sampled at each edge. 1 is the internal pacer, which fires every `cfg_pacer_div`+1 cycles while the block is busy. 2 is a rising edge on `ext_trig`. 3 selects no trigger.
- R6: In burst mode one trigger produces `cfg_block` conversions on successive entries, with a block count of 0 treated as 1. Each later entry is applied `cfg_gap`+1 edges after the edge at which the previous completion was sampled.
- R7: A trigger that arrives while the block is busy but not waiting raises `overrun` for one cycle on the next cycle. It starts no conversion.
- R8: An `adc_done` sampled while a conversion is pending gives a one-cycle `res_valid` on the next cycle, with `res_index` set to the entry's list index and `res_chan` set to its channel.
- R9: `cmd_stop` during a pending conversion lets that conversion complete and deliver its result, then returns the block to idle. At any other busy time it returns the block to idle at the next edge. Either way the next start begins at entry 0.
- R10: An `adc_done` that arrives when no conversion is pending produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lw_en | input | 1 | List write enable |
| lw_addr | input | IDX_W | List entry to write |
| lw_chan | input | CH_W | Channel address to store |
| lw_gain | input | GAIN_W | Gain code to store |
| cfg_last | input | IDX_W | Index of the final list entry |
| cfg_burst | input | 1 | 1 selects burst mode, 0 continuous |
| cfg_block | input | BLK_W | Conversions per burst |
| cfg_settle | input | CNT_W | Settle cycles before conversion start |
| cfg_gap | input | CNT_W | Extra spacing cycles between burst conversions |
| cfg_src | input | 2 | Trigger source select |
| cfg_pacer_div | input | CNT_W | Pacer period minus one |
| cmd_start | input | 1 | Begin acquisition (honoured when idle) |
| cmd_stop | input | 1 | End acquisition |
| sw_trig | input | 1 | Software trigger |
| ext_trig | input | 1 | External trigger, rising edge used |
| adc_done | input | 1 | Converter completion |
| mux_addr | output | CH_W | Multiplexer channel address |
| gain_code | output | GAIN_W | Amplifier gain code |
| conv_start | output | 1 | Conversion start pulse |
| res_valid | output | 1 | Result tag valid |
| res_index | output | IDX_W | List index of the result |
| res_chan | output | CH_W | Channel of the result |
| overrun | output | 1 | Trigger dropped while busy |
| busy | output | 1 | Acquisition running |

## Verification
The bench builds the block with an eight-entry list, 4-bit channels and 8-bit counters, and it sets the list length to six. This makes the wrap from the last programmed entry back to entry 0 happen well before the end of physical storage, and a repeated channel shows up within the first handful of triggers. Settle, spacing and pacer values of a few cycles, together with a converter model that answers three cycles after each start, mean that overruns, a stop during a conversion, bursts with a block count of 0 and of 3, and pacer and external triggering all occur within a few hundred cycles.

// File: rtl/scan_seq_pkg.sv
// Shared types for the scan sequencer: controller states and trigger codes.
package scan_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WAIT   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_CONV   = 3'd3,
        ST_GAP    = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        TRG_SW    = 2'd0,
        TRG_PACER = 2'd1,
        TRG_EXT   = 2'd2,
        TRG_NONE  = 2'd3
    } trig_src_t;
endpackage

// File: rtl/scan_list_ram.sv
// Entry storage for the scan list. Every entry is a register pair
// (channel, gain) with a single write port and a combinational read port.
// Assumes DEPTH is a power of two so every index value names an entry.
module scan_list_ram #(
    parameter int DEPTH  = 8,
    parameter int CH_W   = 4,
    parameter int GAIN_W = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [GAIN_W-1:0] wr_gain,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CH_W-1:0]   rd_chan,
    output logic [GAIN_W-1:0] rd_gain
);
    logic [CH_W-1:0]   chan_q [DEPTH];
    logic [GAIN_W-1:0] gain_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // Store one entry when the host addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chan_q[e] <= '0;
                gain_q[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                chan_q[e] <= wr_chan;
                gain_q[e] <= wr_gain;
            end
        end
    end

    // Present the entry selected by the controller.
    always_comb begin
        rd_chan = chan_q[rd_idx];
        rd_gain = gain_q[rd_idx];
    end
endmodule

// File: rtl/scan_trig_gen.sv
// Trigger source selection: software level, internal pacer, or external
// rising edge. The pacer only counts while the sequencer is running.
// Assumes sw_trig and ext_trig are already synchronous to clk.
module scan_trig_gen
    import scan_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       src,
    input  logic [CNT_W-1:0] pacer_div,
    input  logic             sw_trig,
    input  logic             ext_trig,
    output logic             trig
);
    logic [CNT_W-1:0] pace_cnt;
    logic             ext_q;
    logic             pace_tick;

    assign pace_tick = run && (pace_cnt == pacer_div);

    // Pacer counter: free-runs modulo pacer_div+1 while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pace_cnt <= '0;
        end else if (!run || pace_tick) begin
            pace_cnt <= '0;
        end else begin
            pace_cnt <= pace_cnt + CNT_W'(1);
        end
    end

    // Remember the external input to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_trig;
    end

    // Select the active trigger source.
    always_comb begin
        unique case (trig_src_t'(src))
            TRG_SW:    trig = sw_trig;
            TRG_PACER: trig = pace_tick;
            TRG_EXT:   trig = ext_trig && !ext_q;
            default:   trig = 1'b0;
        endcase
    end
endmodule

// File: rtl/scan_seq_ctrl.sv
// Sequencing controller: walks the list, applies channel/gain, waits the
// settle time, pulses conversion start, tags results, runs bursts with a
// spacing counter, flags overruns and handles stop.
// Assumes configuration inputs stay constant while busy.
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int CH_W   = 4,
    parameter int GAIN_W = 2,
    parameter int CNT_W  = 8,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              trig,
    input  logic              adc_done,
    input  logic              burst_mode,
    input  logic [IDX_W-1:0]  cfg_last,
    input  logic [BLK_W-1:0]  cfg_block,
    input  logic [CNT_W-1:0]  cfg_settle,
    input  logic [CNT_W-1:0]  cfg_gap,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [CH_W-1:0]   rd_chan,
    input  logic [GAIN_W-1:0] rd_gain,
    output logic [CH_W-1:0]   mux_addr,
    output logic [GAIN_W-1:0] gain_code,
    output logic              conv_start,
    output logic              res_valid,
    output logic [IDX_W-1:0]  res_index,
    output logic [CH_W-1:0]   res_chan,
    output logic              overrun,
    output logic              busy
);
    seq_state_t       state;
    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] cur_idx;
    logic [CNT_W-1:0] wait_cnt;
    logic [BLK_W-1:0] remaining;
    logic             stop_pend;
    logic [IDX_W-1:0] ptr_next;
    logic [BLK_W-1:0] blk_extra;

    assign busy      = (state != ST_IDLE);
    assign rd_idx    = ptr;
    assign ptr_next  = (ptr == cfg_last) ? '0 : ptr + IDX_W'(1);
    assign blk_extra = (cfg_block == '0) ? '0 : cfg_block - BLK_W'(1);

    // Main sequencing state machine with registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ptr        <= '0;
            cur_idx    <= '0;
            wait_cnt   <= '0;
            remaining  <= '0;
            stop_pend  <= 1'b0;
            mux_addr   <= '0;
            gain_code  <= '0;
            conv_start <= 1'b0;
            res_valid  <= 1'b0;
            res_index  <= '0;
            res_chan   <= '0;
            overrun    <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            res_valid  <= 1'b0;
            overrun    <= trig && busy && (state != ST_WAIT);
            unique case (state)
                ST_IDLE: begin
                    if (cmd_start && !cmd_stop) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (cmd_stop) begin
                        state <= ST_IDLE;
                        ptr   <= '0;
                    end else if (trig) begin
                        mux_addr  <= rd_chan;
                        gain_code <= rd_gain;
                        cur_idx   <= ptr;
                        wait_cnt  <= cfg_settle;
                        remaining <= burst_mode ? blk_extra : '0;
                        state     <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (cmd_stop) begin
                        state <= ST_IDLE;
                        ptr   <= '0;
                    end else if (wait_cnt == '0) begin
                        conv_start <= 1'b1;
                        state      <= ST_CONV;
                    end else begin
                        wait_cnt <= wait_cnt - CNT_W'(1);
                    end
                end
                ST_CONV: begin
                    if (cmd_stop) stop_pend <= 1'b1;
                    if (adc_done) begin
                        res_valid <= 1'b1;
                        res_index <= cur_idx;
                        res_chan  <= mux_addr;
                        if (cmd_stop || stop_pend) begin
                            state     <= ST_IDLE;
                            ptr       <= '0;
                            stop_pend <= 1'b0;
                        end else begin
                            ptr <= ptr_next;
                            if (remaining != '0) begin
                                remaining <= remaining - BLK_W'(1);
                                wait_cnt  <= cfg_gap;
                                state     <= ST_GAP;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (cmd_stop) begin
                        state <= ST_IDLE;
                        ptr   <= '0;
                    end else if (wait_cnt == '0) begin
                        mux_addr  <= rd_chan;
                        gain_code <= rd_gain;
                        cur_idx   <= ptr;
                        wait_cnt  <= cfg_settle;
                        state     <= ST_SETTLE;
                    end else begin
                        wait_cnt <= wait_cnt - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scan_sequencer.sv
// Top level of the scan sequencer: list storage, trigger generation and
// the sequencing controller. Assumes all inputs are synchronous to clk.
module scan_sequencer #(
    parameter int DEPTH  = 8,
    parameter int CH_W   = 4,
    parameter int GAIN_W = 2,
    parameter int CNT_W  = 8,
    parameter int BLK_W  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lw_en,
    input  logic [IDX_W-1:0]  lw_addr,
    input  logic [CH_W-1:0]   lw_chan,
    input  logic [GAIN_W-1:0] lw_gain,
    input  logic [IDX_W-1:0]  cfg_last,
    input  logic              cfg_burst,
    input  logic [BLK_W-1:0]  cfg_block,
    input  logic [CNT_W-1:0]  cfg_settle,
    input  logic [CNT_W-1:0]  cfg_gap,
    input  logic [1:0]        cfg_src,
    input  logic [CNT_W-1:0]  cfg_pacer_div,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              sw_trig,
    input  logic              ext_trig,
    input  logic              adc_done,
    output logic [CH_W-1:0]   mux_addr,
    output logic [GAIN_W-1:0] gain_code,
    output logic              conv_start,
    output logic              res_valid,
    output logic [IDX_W-1:0]  res_index,
    output logic [CH_W-1:0]   res_chan,
    output logic              overrun,
    output logic              busy
);
    logic [IDX_W-1:0]  rd_idx;
    logic [CH_W-1:0]   rd_chan;
    logic [GAIN_W-1:0] rd_gain;
    logic              trig;

    scan_list_ram #(.DEPTH(DEPTH), .CH_W(CH_W), .GAIN_W(GAIN_W)) u_list (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lw_en), .wr_idx(lw_addr), .wr_chan(lw_chan), .wr_gain(lw_gain),
        .rd_idx(rd_idx), .rd_chan(rd_chan), .rd_gain(rd_gain)
    );

    scan_trig_gen #(.CNT_W(CNT_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .run(busy), .src(cfg_src),
        .pacer_div(cfg_pacer_div), .sw_trig(sw_trig), .ext_trig(ext_trig),
        .trig(trig)
    );

    scan_seq_ctrl #(
        .IDX_W(IDX_W), .CH_W(CH_W), .GAIN_W(GAIN_W), .CNT_W(CNT_W), .BLK_W(BLK_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .trig(trig), .adc_done(adc_done), .burst_mode(cfg_burst),
        .cfg_last(cfg_last), .cfg_block(cfg_block), .cfg_settle(cfg_settle),
        .cfg_gap(cfg_gap), .rd_idx(rd_idx), .rd_chan(rd_chan), .rd_gain(rd_gain),
        .mux_addr(mux_addr), .gain_code(gain_code), .conv_start(conv_start),
        .res_valid(res_valid), .res_index(res_index), .res_chan(res_chan),
        .overrun(overrun), .busy(busy)
    );
endmodule

// File: rtl/scan_sequencer_chk.sv
// Protocol checker for the scan sequencer, attached by bind.
module scan_sequencer_chk #(
    parameter int CH_W   = 4,
    parameter int GAIN_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_done,
    input logic [CH_W-1:0]   mux_addr,
    input logic [GAIN_W-1:0] gain_code,
    input logic              conv_start,
    input logic              res_valid,
    input logic              overrun,
    input logic              busy
);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r2_settled_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($stable(mux_addr) && $stable(gain_code)));

    a_r2_held_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> ($stable(mux_addr) && $stable(gain_code)));

    a_r8_result_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(adc_done));

    a_r7_overrun_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(busy));

    a_r9_idle_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !conv_start);

    a_r10_result_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(busy));
endmodule

bind scan_sequencer scan_sequencer_chk #(.CH_W(CH_W), .GAIN_W(GAIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_done(adc_done), .mux_addr(mux_addr),
    .gain_code(gain_code), .conv_start(conv_start), .res_valid(res_valid),
    .overrun(overrun), .busy(busy)
);

// File: tb/scan_sequencer_test.sv
module scan_sequencer_test;
    localparam int DEPTH = 8, CH_W = 4, GAIN_W = 2, CNT_W = 8, BLK_W = 4;
    localparam int IDX_W = 3;
    localparam int ADC_LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lw_en = 1'b0;
    logic [IDX_W-1:0] lw_addr = '0;
    logic [CH_W-1:0] lw_chan = '0;
    logic [GAIN_W-1:0] lw_gain = '0;
    logic [IDX_W-1:0] cfg_last = 3'd5;
    logic cfg_burst = 1'b0;
    logic [BLK_W-1:0] cfg_block = 4'd1;
    logic [CNT_W-1:0] cfg_settle = 8'd2;
    logic [CNT_W-1:0] cfg_gap = 8'd1;
    logic [1:0] cfg_src = 2'd0;
    logic [CNT_W-1:0] cfg_pacer_div = 8'd19;
    logic cmd_start = 1'b0, cmd_stop = 1'b0, sw_trig = 1'b0, ext_trig = 1'b0;
    logic adc_done = 1'b0;
    logic force_done = 1'b0;
    logic [CH_W-1:0] mux_addr;
    logic [GAIN_W-1:0] gain_code;
    logic conv_start, res_valid, overrun, busy;
    logic [IDX_W-1:0] res_index;
    logic [CH_W-1:0] res_chan;

    scan_sequencer #(.DEPTH(DEPTH), .CH_W(CH_W), .GAIN_W(GAIN_W), .CNT_W(CNT_W), .BLK_W(BLK_W)) uut (
        .clk(clk), .rst_n(rst_n), .lw_en(lw_en), .lw_addr(lw_addr), .lw_chan(lw_chan),
        .lw_gain(lw_gain), .cfg_last(cfg_last), .cfg_burst(cfg_burst), .cfg_block(cfg_block),
        .cfg_settle(cfg_settle), .cfg_gap(cfg_gap), .cfg_src(cfg_src),
        .cfg_pacer_div(cfg_pacer_div), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .sw_trig(sw_trig), .ext_trig(ext_trig), .adc_done(adc_done),
        .mux_addr(mux_addr), .gain_code(gain_code), .conv_start(conv_start),
        .res_valid(res_valid), .res_index(res_index), .res_chan(res_chan),
        .overrun(overrun), .busy(busy)
    );

    always #10 clk = ~clk;

    int vectors = 0, errors = 0, cycles = 0;
    bit started = 0, done_flag = 0;
    int n_res = 0, n_cs = 0, n_ovr = 0;
    int q_ch[$], q_ix[$];

    // Reference model state (integers, behavioural)
    int ms, mptr, mcur, mcnt, mrem, mpc;
    bit mstop, mextq, mcs, mrv, movr, run, tick, trg;
    int mmux, mgain, mri, mrc;
    int lch[DEPTH], lgn[DEPTH];

    task automatic load_entry();
        mmux = lch[mptr]; mgain = lgn[mptr]; mcur = mptr; mcnt = int'(cfg_settle); ms = 2;
    endtask

    task automatic go_idle();
        ms = 0; mptr = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mptr = 0; mcur = 0; mcnt = 0; mrem = 0; mpc = 0; mstop = 0; mextq = 0;
            mcs = 0; mrv = 0; movr = 0; mmux = 0; mgain = 0; mri = 0; mrc = 0;
            for (int i = 0; i < DEPTH; i++) begin lch[i] = 0; lgn[i] = 0; end
        end else begin
            run = (ms != 0);
            tick = run && (mpc == int'(cfg_pacer_div));
            case (cfg_src)
                2'd0: trg = sw_trig;
                2'd1: trg = tick;
                2'd2: trg = ext_trig && !mextq;
                default: trg = 0;
            endcase
            mpc = (!run || tick) ? 0 : mpc + 1;
            mextq = ext_trig;
            movr = trg && run && (ms != 1);
            mcs = 0; mrv = 0;
            case (ms)
                0: if (cmd_start && !cmd_stop) ms = 1;
                1: if (cmd_stop) go_idle();
                   else if (trg) begin
                       load_entry();
                       mrem = cfg_burst ? ((cfg_block == 0) ? 0 : int'(cfg_block) - 1) : 0;
                   end
                2: if (cmd_stop) go_idle();
                   else if (mcnt == 0) begin mcs = 1; ms = 3; end
                   else mcnt--;
                3: begin
                    if (cmd_stop) mstop = 1;
                    if (adc_done) begin
                        mrv = 1; mri = mcur; mrc = mmux;
                        if (mstop) begin go_idle(); mstop = 0; end
                        else begin
                            mptr = (mptr == int'(cfg_last)) ? 0 : mptr + 1;
                            if (mrem > 0) begin mrem--; mcnt = int'(cfg_gap); ms = 4; end
                            else ms = 1;
                        end
                    end
                end
                4: if (cmd_stop) go_idle();
                   else if (mcnt == 0) load_entry();
                   else mcnt--;
                default: ms = 0;
            endcase
            if (lw_en) begin lch[lw_addr] = int'(lw_chan); lgn[lw_addr] = int'(lw_gain); end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    // Per-clock comparison against the model, plus a converter responder.
    int adc_cnt = 0;
    always @(negedge clk) begin
        if (started) begin
            chk(int'(mux_addr) == mmux && int'(gain_code) == mgain, "R2 chan/gain",
                int'({mux_addr, gain_code}), (mmux << GAIN_W) | mgain);
            chk(conv_start == mcs, "R3 conv_start", int'(conv_start), int'(mcs));
            chk(res_valid == mrv && (!mrv || (int'(res_index) == mri && int'(res_chan) == mrc)),
                "R8 result tag", int'({res_valid, res_index, res_chan}), (int'(mrv) << 7) | (mri << 4) | mrc);
            chk(overrun == movr, "R7 overrun", int'(overrun), int'(movr));
            chk(busy == (ms != 0), "R9 busy", int'(busy), int'(ms != 0));
            if (res_valid) begin n_res++; q_ch.push_back(int'(res_chan)); q_ix.push_back(int'(res_index)); end
            if (conv_start) n_cs++;
            if (overrun) n_ovr++;
        end
        if (conv_start) adc_cnt = ADC_LAT;
        else if (adc_cnt > 0) adc_cnt--;
        adc_done = (adc_cnt == 1) || force_done;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; vectors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic pulse_start(); cmd_start = 1; @(negedge clk); cmd_start = 0; endtask
    task automatic pulse_stop();  cmd_stop = 1;  @(negedge clk); cmd_stop = 0;  endtask
    task automatic pulse_sw();    sw_trig = 1;   @(negedge clk); sw_trig = 0;   endtask

    int chans[DEPTH] = '{5, 1, 11, 1, 7, 3, 9, 2};
    int base;

    initial begin
        tick_n(3);
        rst_n = 1;
        started = 1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !conv_start && !res_valid && !overrun && mux_addr == 0 && gain_code == 0,
            "R1 reset state", int'({busy, conv_start, res_valid, overrun}), 0);

        for (int i = 0; i < DEPTH; i++) begin
            lw_en = 1; lw_addr = IDX_W'(i); lw_chan = CH_W'(chans[i]); lw_gain = GAIN_W'(i % 4);
            @(negedge clk);
        end
        lw_en = 0;

        // R4: continuous scan with wrap at entry 5 and a repeated channel
        pulse_start();
        for (int t = 0; t < 8; t++) begin pulse_sw(); tick_n(14); end
        chk(n_res == 8, "R4 one result per trigger", n_res, 8);
        for (int k = 0; k < 8; k++) begin
            chk(q_ix[k] == k % 6, "R4 index order", q_ix[k], k % 6);
            chk(q_ch[k] == chans[k % 6], "R4 channel order", q_ch[k], chans[k % 6]);
        end

        // R7: trigger during a conversion
        base = n_res;
        pulse_sw(); tick_n(2); pulse_sw(); tick_n(14);
        chk(n_ovr == 1, "R7 overrun count", n_ovr, 1);
        chk(n_res == base + 1, "R7 no extra conversion", n_res, base + 1);

        // R10: stray completion while waiting
        base = n_res;
        force_done = 1; @(negedge clk); force_done = 0; tick_n(4);
        chk(n_res == base, "R10 stray done ignored", n_res, base);

        // R9: stop during a pending conversion
        base = n_res;
        pulse_sw();
        while (!conv_start) @(negedge clk);
        pulse_stop(); tick_n(8);
        chk(n_res == base + 1, "R9 result delivered", n_res, base + 1);
        chk(!busy, "R9 idle after stop", int'(busy), 0);
        pulse_start(); pulse_sw(); tick_n(14);
        chk(q_ix[q_ix.size()-1] == 0, "R9 restart at entry 0", q_ix[q_ix.size()-1], 0);
        pulse_stop(); tick_n(2);

        // R6: burst of three, then block count 0
        cfg_burst = 1; cfg_block = 4'd3; cfg_gap = 8'd1;
        base = n_cs;
        pulse_start(); pulse_sw(); tick_n(50);
        chk(n_cs == base + 3, "R6 burst conversions", n_cs - base, 3);
        chk(q_ix[q_ix.size()-1] == 2, "R6 successive entries", q_ix[q_ix.size()-1], 2);
        cfg_block = 4'd0; base = n_cs;
        pulse_sw(); tick_n(30);
        chk(n_cs == base + 1, "R6 block zero acts as one", n_cs - base, 1);
        pulse_stop(); tick_n(2);

        // R5: pacer trigger, period 20 cycles
        cfg_burst = 0; cfg_src = 2'd1; base = n_res;
        pulse_start(); tick_n(200); pulse_stop(); tick_n(10);
        chk(n_res - base >= 8, "R5 pacer conversions", n_res - base, 9);

        // R5: external rising edges, level held does not retrigger
        cfg_src = 2'd2; base = n_res;
        pulse_start();
        ext_trig = 1; tick_n(30); ext_trig = 0; tick_n(5); ext_trig = 1; tick_n(30); ext_trig = 0;
        tick_n(5);
        chk(n_res == base + 2, "R5 external edges", n_res - base, 2);

        // R5: source 3 ignores the software strobe
        cfg_src = 2'd3; base = n_res;
        pulse_sw(); tick_n(15);
        chk(n_res == base, "R5 no source selected", n_res - base, 0);
        pulse_stop(); tick_n(3);

        finish_run();
    end
endmodule